// File: doc/BRIEF.md
# Incoming Sample Rate Classifier

This block estimates the sample rate of an incoming digital audio stream and reports it as a 3-bit rate code. It runs entirely on a fixed reference clock (nominally 6.144 MHz). A frame strobe arrives from the recovered-clock domain, and its rising edge marks the start of each audio frame. A block-start marker, sampled together with the strobe, flags the first frame of each 192-frame channel-status block. The block counts reference cycles across windows of 64 frames, so a block holds three windows. At the close of each window it compares the count against tolerance ranges around the nominal count of each standard rate.

Measurement runs only while both the enable input and the PLL lock flag are high. When either is low the code is forced to "out of range" and any partial measurement is thrown away. Both the frame strobe and the block marker pass through a two-flop synchronizer before use. Each must stay high and low for at least two reference cycles.

Top module: `srate_monitor`

## Requirements
- R1: The rate code reads 3'b011 for 96 kHz, 3'b100 for 88.2 kHz, 3'b101 for 48 kHz, 3'b110 for 44.1 kHz and 3'b111 for 32 kHz.
- R2: The codes 3'b001 and 3'b010 are never produced. A closed window whose count falls in no rate range yields 3'b000.
- R3: The nominal count is N = REF_HZ * 64 / rate. A window count c selects a rate when 0.96*N <= c <= 1.04*N, and both limits are inclusive.
- R4: A window spans 64 frame strobes, and three windows make a 192-frame block. The frame that carries the block-start marker is frame 0. The code changes only when a window closes, and it holds its value in between.
- R5: When meas_en or pll_lock is low, the code becomes 3'b000 at the next clock edge and the window in progress is discarded.
- R6: After the block becomes active again, the code stays 3'b000 until the first window that opens after reactivation has closed.
- R7: A block-start marker on a frame other than frame 0 of the block has three effects: the partial window is discarded, the code is held, and a new window opens at that frame.
- R8: The window counter saturates at 2^CNT_W-1. A window longer than every range yields 3'b000.
- R9: A window's result appears on the code output no later than three reference clock rising edges after the closing frame strobe is driven high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock, nominally 6.144 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_in | input | 1 | Frame strobe from the recovered domain; its rising edge starts a frame |
| blk_in | input | 1 | Block-start marker, held high during the high phase of frame 0 |
| pll_lock | input | 1 | High while the receiver PLL is locked |
| meas_en | input | 1 | Measurement enable |
| rate_code | output | 3 | Registered sample-rate code |

## Verification
The bench drives windows whose counts sit exactly on, and one cycle outside, every rate's lower and upper limit. An off-by-one in rounding or an exclusive compare would misreport one of those windows. It removes the enable and then the lock in the middle of a window. It checks that the code drops at once and that the next window, which did not start after reactivation, does not publish a stale count. A late block-start marker is injected after ten frames; a design that closed the short window would publish a code for a wrong count. An over-long window drives the counter to saturation, which must give 3'b000 rather than wrap into a valid range.

// File: rtl/srate_pkg.sv
// Shared types and limit arithmetic for the sample-rate classifier.
// Assumes rates are listed fastest first; the code of entry i is 3 + i.
package srate_pkg;

    localparam int NUM_RATES = 5;

    typedef enum logic [2:0] {
        SR_NONE = 3'd0,
        SR_RSV1 = 3'd1,
        SR_RSV2 = 3'd2,
        SR_96K  = 3'd3,
        SR_88K2 = 3'd4,
        SR_48K  = 3'd5,
        SR_44K1 = 3'd6,
        SR_32K  = 3'd7
    } srate_code_e;

    // Nominal rate of entry idx in tenths of a hertz.
    function automatic logic [63:0] rate_dhz(input int idx);
        case (idx)
            0:       return 64'd960000;
            1:       return 64'd882000;
            2:       return 64'd480000;
            3:       return 64'd441000;
            default: return 64'd320000;
        endcase
    endfunction

    // Count limit for entry idx: lower limit rounded up, upper rounded down.
    function automatic logic [63:0] win_limit(input logic [63:0] ref_hz,
                                              input logic [63:0] frames,
                                              input logic [63:0] tol_pct,
                                              input int          idx,
                                              input bit          upper);
        logic [63:0] num;
        logic [63:0] den;
        num = ref_hz * frames * 64'd10 * (upper ? (64'd100 + tol_pct) : (64'd100 - tol_pct));
        den = rate_dhz(idx) * 64'd100;
        return upper ? (num / den) : ((num + den - 64'd1) / den);
    endfunction

    // Code reported for entry idx.
    function automatic srate_code_e code_of(input int idx);
        return srate_code_e'(3'(idx + 3));
    endfunction

endpackage

// File: rtl/srate_sync.sv
// Multi-stage synchronizer for a bundle of slow level signals.
// Assumes each bit holds its level for at least STAGES destination cycles.
module srate_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Move the value one stage deeper.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/srate_cadence.sv
// Tracks the frame position inside a block and flags window boundaries.
// Assumes synchronized inputs; the block marker is valid whenever the frame edge is seen.
module srate_cadence #(
    parameter int WIN_FRAMES     = 64,
    parameter int WINS_PER_BLOCK = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_s,
    input  logic blk_s,
    output logic bound,
    output logic misalign
);
    localparam int FP_W = (WIN_FRAMES > 1) ? $clog2(WIN_FRAMES) : 1;
    localparam int WP_W = (WINS_PER_BLOCK > 1) ? $clog2(WINS_PER_BLOCK) : 1;
    localparam logic [FP_W-1:0] FP_LAST = FP_W'(WIN_FRAMES - 1);
    localparam logic [WP_W-1:0] WP_LAST = WP_W'(WINS_PER_BLOCK - 1);

    logic            frame_d;
    logic            evt;
    logic [FP_W-1:0] fpos;
    logic [WP_W-1:0] wpos;
    logic [FP_W-1:0] cur_f;
    logic [WP_W-1:0] cur_w;

    // Frame start detection and position of the arriving frame.
    always_comb begin
        evt   = frame_s & ~frame_d;
        cur_f = blk_s ? '0 : fpos;
        cur_w = blk_s ? '0 : wpos;
    end

    // Boundary and out-of-cadence marker flags.
    always_comb begin
        bound    = evt && (cur_f == '0);
        misalign = evt && blk_s && ((fpos != '0) || (wpos != '0));
    end

    // Advance the frame and window position on each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_d <= 1'b0;
            fpos    <= '0;
            wpos    <= '0;
        end else begin
            frame_d <= frame_s;
            if (evt) begin
                if (cur_f == FP_LAST) begin
                    fpos <= '0;
                    wpos <= (cur_w == WP_LAST) ? '0 : cur_w + 1'b1;
                end else begin
                    fpos <= cur_f + 1'b1;
                    wpos <= cur_w;
                end
            end
        end
    end

    p_pos_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fpos <= FP_LAST) && (wpos <= WP_LAST));

    p_misalign_realign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> (wpos == '0) && (fpos == FP_W'(1 % WIN_FRAMES)));
endmodule

// File: rtl/srate_window_counter.sv
// Counts reference cycles between window boundaries, saturating at all ones.
// Assumes restart is a one-cycle pulse on every boundary frame.
module srate_window_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             armed
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    // Clear when idle, reopen on a boundary, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            armed <= 1'b0;
        end else if (!active) begin
            count <= '0;
            armed <= 1'b0;
        end else if (restart) begin
            count <= CNT_W'(1);
            armed <= 1'b1;
        end else if (armed && (count != SAT)) begin
            count <= count + 1'b1;
        end
    end

    p_cnt_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !restart && (count == SAT)) |=> (count == SAT));
endmodule

// File: rtl/srate_classify.sv
// Compares a window count against the tolerance range of every standard rate.
// Assumes ranges do not overlap for the chosen reference and window length.
module srate_classify
    import srate_pkg::*;
#(
    parameter int REF_HZ     = 6144000,
    parameter int WIN_FRAMES = 64,
    parameter int TOL_PCT    = 4,
    parameter int CNT_W      = 15
) (
    input  logic [CNT_W-1:0]     count,
    output logic [NUM_RATES-1:0] hit,
    output srate_code_e          code
);
    logic [63:0] cnt64;
    assign cnt64 = 64'(count);

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam logic [63:0] LO = win_limit(64'(REF_HZ), 64'(WIN_FRAMES), 64'(TOL_PCT), g, 1'b0);
        localparam logic [63:0] HI = win_limit(64'(REF_HZ), 64'(WIN_FRAMES), 64'(TOL_PCT), g, 1'b1);
        assign hit[g] = (cnt64 >= LO) && (cnt64 <= HI);
    end

    // Encode the matching range, or out of range when none matches.
    always_comb begin
        code = SR_NONE;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (hit[i]) code = code_of(i);
        end
    end
endmodule

// File: rtl/srate_monitor.sv
// Top level: synchronizes the frame strobe and the block marker, times windows, and registers the code.
// Assumes clk_ref is the reference clock; meas_en and pll_lock are already in its domain.
module srate_monitor
    import srate_pkg::*;
#(
    parameter int REF_HZ         = 6144000,
    parameter int WIN_FRAMES     = 64,
    parameter int WINS_PER_BLOCK = 3,
    parameter int TOL_PCT        = 4,
    parameter int CNT_W          = 15,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       frame_in,
    input  logic       blk_in,
    input  logic       pll_lock,
    input  logic       meas_en,
    output logic [2:0] rate_code
);
    logic [1:0]           sync_q;
    logic                 bound;
    logic                 misalign;
    logic                 active;
    logic                 close_evt;
    logic                 armed;
    logic [CNT_W-1:0]     count;
    logic [NUM_RATES-1:0] hit;
    srate_code_e          cls_code;
    srate_code_e          code_q;

    srate_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     ({blk_in, frame_in}),
        .q     (sync_q)
    );

    srate_cadence #(.WIN_FRAMES(WIN_FRAMES), .WINS_PER_BLOCK(WINS_PER_BLOCK)) u_cad (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .frame_s  (sync_q[0]),
        .blk_s    (sync_q[1]),
        .bound    (bound),
        .misalign (misalign)
    );

    srate_window_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .active  (active),
        .restart (bound),
        .count   (count),
        .armed   (armed)
    );

    srate_classify #(.REF_HZ(REF_HZ), .WIN_FRAMES(WIN_FRAMES), .TOL_PCT(TOL_PCT), .CNT_W(CNT_W)) u_cls (
        .count (count),
        .hit   (hit),
        .code  (cls_code)
    );

    // Qualify measurement and decide when a full window closes.
    always_comb begin
        active    = meas_en & pll_lock;
        close_evt = active && bound && armed && !misalign;
    end

    // Register the code: cleared when idle, refreshed at each window close.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)         code_q <= SR_NONE;
        else if (!active)   code_q <= SR_NONE;
        else if (close_evt) code_q <= cls_code;
    end

    assign rate_code = code_q;

    p_ranges_disjoint_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $onehot0(hit));

    p_no_reserved_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (rate_code != 3'd1) && (rate_code != 3'd2));

    p_idle_zero_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !active |=> (rate_code == 3'd0));

    p_update_cadence_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$stable(rate_code) |-> $past(close_evt || !active));
endmodule

// File: tb/sim_srate_monitor.sv
// Bench: directed limit windows, disruptions, a late block marker and random windows.
module sim_srate_monitor;
    localparam int REF = 768000;
    localparam int WIN = 64;
    localparam int CW  = 12;
    localparam int SAT = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_in;
    logic       blk_in;
    logic       pll_lock;
    logic       meas_en;
    logic [2:0] rate_code;

    always #4 clk = ~clk;

    srate_monitor #(.REF_HZ(REF), .CNT_W(CW)) u0 (
        .clk_ref   (clk),
        .rst_n     (rst_n),
        .frame_in  (frame_in),
        .blk_in    (blk_in),
        .pll_lock  (pll_lock),
        .meas_en   (meas_en),
        .rate_code (rate_code)
    );

    int         errs = 0;
    int         checks = 0;
    logic [2:0] model_code = 3'd0;
    bit         model_armed = 1'b0;
    int         prev_total = 0;
    string      prev_req = "R6";
    int         win_no = 0;

    function automatic longint dhz(int i);
        case (i)
            0: return 960000;
            1: return 882000;
            2: return 480000;
            3: return 441000;
            default: return 320000;
        endcase
    endfunction

    // R3: inclusive +-4% limits, lower rounded up, upper rounded down.
    function automatic longint lim(int i, bit up);
        longint num;
        longint den;
        num = longint'(REF) * WIN * (up ? 1040 : 960);
        den = dhz(i) * 100;
        return up ? (num / den) : ((num + den - 1) / den);
    endfunction

    function automatic longint nominal(int i);
        return (longint'(REF) * WIN * 10) / dhz(i);
    endfunction

    // R1, R2, R8: expected code for a window of total cycles.
    function automatic logic [2:0] exp_code(int total);
        longint c;
        c = (total > SAT) ? SAT : total;
        for (int i = 0; i < 5; i++) begin
            if (c >= lim(i, 1'b0) && c <= lim(i, 1'b1)) return 3'(3 + i);
        end
        return 3'd0;
    endfunction

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: rate_code=%b expected %b", req, act, exp);
        end
    endtask

    // One frame of len cycles, starting at a falling edge; R9 check after three rising edges.
    task automatic send_frame(int len, bit blk, bit do_chk, string req);
        int hi;
        hi = len / 2;
        frame_in = 1'b1;
        blk_in   = blk;
        for (int c = 1; c <= len; c++) begin
            @(negedge clk);
            if (c == 3 && do_chk) chk(req, rate_code, model_code);
            if (c == hi) begin
                frame_in = 1'b0;
                blk_in   = 1'b0;
            end
        end
    endtask

    // Boundary frame: closes the previous window in the model unless misaligned (R7).
    task automatic open_frame(int len, bit blk, bit misal);
        string lbl;
        lbl = misal ? "R7" : prev_req;
        if (model_armed && !misal) model_code = exp_code(prev_total);
        model_armed = 1'b1;
        send_frame(len, blk, 1'b1, lbl);
    endtask

    // One 64-frame window of exactly total cycles; dis=1 drops enable, dis=2 drops lock mid-window.
    task automatic run_window(int total, string req, bit misal, int dis);
        int base;
        int rem;
        bit blk;
        base = total / WIN;
        rem  = total % WIN;
        blk  = misal || (win_no % 3 == 0);
        open_frame(base + ((rem > 0) ? 1 : 0), blk, misal);
        for (int i = 1; i < WIN; i++) begin
            if (dis != 0 && i == 20) begin
                if (dis == 1) meas_en = 1'b0;
                else          pll_lock = 1'b0;
                model_code  = 3'd0;
                model_armed = 1'b0;
                @(negedge clk);
                @(negedge clk);
                chk("R5", rate_code, 3'd0);
                meas_en  = 1'b1;
                pll_lock = 1'b1;
                @(negedge clk);
            end
            send_frame(base + ((i < rem) ? 1 : 0), 1'b0, 1'b0, "");
        end
        prev_total = total;
        prev_req   = (dis != 0) ? "R6" : req;
        win_no     = misal ? 1 : win_no + 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: rate_code=%b expected run to finish", rate_code);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int r;
        int tot;
        int pct;
        r = $urandom(32'd20240611);
        rst_n    = 1'b0;
        frame_in = 1'b0;
        blk_in   = 1'b0;
        pll_lock = 1'b1;
        meas_en  = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 reset", rate_code, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // First window after reset: nothing published at its close (R6).
        run_window(int'(nominal(2)), "R1 R9", 1'b0, 0);

        // R1/R3/R2: nominal, on each limit, one cycle outside each limit.
        for (int i = 0; i < 5; i++) begin
            run_window(int'(nominal(i)),          "R1",    1'b0, 0);
            run_window(int'(lim(i, 1'b0)),        "R3 lo", 1'b0, 0);
            run_window(int'(lim(i, 1'b1)),        "R3 hi", 1'b0, 0);
            run_window(int'(lim(i, 1'b0)) - 1,    "R2 lo", 1'b0, 0);
            run_window(int'(lim(i, 1'b1)) + 1,    "R2 hi", 1'b0, 0);
        end

        // R8: window longer than the counter range.
        run_window(WIN * 80, "R8", 1'b0, 0);
        run_window(int'(nominal(4)), "R4", 1'b0, 0);

        // R5/R6: enable drop, then lock drop.
        run_window(int'(nominal(0)), "R5", 1'b0, 1);
        run_window(int'(nominal(1)), "R6", 1'b0, 0);
        run_window(int'(nominal(3)), "R4", 1'b0, 2);
        run_window(int'(nominal(2)), "R6", 1'b0, 0);
        run_window(int'(nominal(0)), "R4", 1'b0, 0);

        // R7: late block marker ten frames into a window.
        open_frame(16, (win_no % 3 == 0), 1'b0);
        for (int i = 1; i < 10; i++) send_frame(16, 1'b0, 1'b0, "");
        prev_req = "R7";
        run_window(int'(nominal(3)), "R7", 1'b1, 0);
        run_window(int'(nominal(1)), "R4", 1'b0, 0);

        // R4: random windows around all rates, some out of tolerance.
        for (int k = 0; k < 30; k++) begin
            r   = int'($urandom % 5);
            pct = int'($urandom % 13) - 6;
            tot = int'(nominal(r)) + (int'(nominal(r)) * pct) / 100;
            run_window(tot, "R4 rand", 1'b0, 0);
        end

        open_frame(16, (win_no % 3 == 0), 1'b0);
        repeat (8) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule